// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes an external SDRAM from power-up to normal operation. After a synchronous reset it waits a settling period with the command code parked on NOP. It then announces the NOP command and waits a second, longer period. Next it announces a precharge-all and runs a fixed number of forced refreshes at a short, fixed spacing. When the last of these has occurred, it captures the operational refresh interval and the row/column latency values from its inputs, switches the command code to normal operation, releases the data buffer enable and raises init-done. From then on it emits refresh strobes at the captured interval.

Every delay is a parameter in clock cycles, so a simulation can use short values and a chip can use the full ones. The command code is a 2-bit selector that a command decoder downstream turns into device commands. A one-cycle issue strobe marks each point where a new init command becomes current.

Top module: `sdram_pu_seq`

## Requirements
- R1: While reset is high, and in the cycle after it is released, init_cmd is 2'b11, cmd_issue, refresh_stb, buf_en and init_done are 0, and ref_interval_q, ras_q and cas_q are 0.
- R2: Count rising edges with reset low from release, calling the count t. cmd_issue is high for exactly one cycle after edge t = PWRUP_CYC, with init_cmd = 2'b11 (NOP). cmd_issue is low at every t below that.
- R3: cmd_issue is high for exactly one cycle after edge t = PWRUP_CYC + SETTLE_CYC, and init_cmd changes to 2'b10 (precharge-all) there. The code holds 2'b10 until the load.
- R4: During initialization, refresh_stb is high for one cycle after each edge t = PWRUP_CYC + SETTLE_CYC + k*REF_GAP, for k = 1 to REF_NUM. It is low at every other t. No refresh is strobed while the code is 2'b11.
- R5: With D = PWRUP_CYC + SETTLE_CYC + REF_NUM*REF_GAP + 1, the following all hold after edge D. init_done is 1, init_cmd is 2'b00 (normal), and ref_interval_q, ras_q and cas_q equal the op_ref_interval, op_ras and op_cas values present at edge D.
- R6: buf_en is 0 whenever init_done is 0. It becomes 1 together with init_done.
- R7: Once set, init_done stays 1 until reset. After edge D, changes on the op_* inputs have no effect on ref_interval_q, ras_q or cas_q.
- R8: In normal operation, refresh_stb is high after every edge t with t > D and (t - D) a multiple of the captured interval. A captured interval of 0 behaves as 1.
- R9: init_cmd never takes the value 2'b01. It only moves in the order 2'b11, 2'b10, 2'b00, and 2'b00 is held until reset.
- R10: A reset applied at any point in the sequence restarts it from the power-up wait, with the timing of R2 to R5 counted from the new release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| op_ref_interval | input | REF_W | Operational refresh interval in cycles, captured at the load |
| op_ras | input | TIM_W | Operational row latency, captured at the load |
| op_cas | input | TIM_W | Operational column latency, captured at the load |
| init_cmd | output | 2 | Command select: 11 NOP, 10 precharge-all, 00 normal |
| cmd_issue | output | 1 | One-cycle strobe when a new init command becomes current |
| refresh_stb | output | 1 | One-cycle refresh request |
| buf_en | output | 1 | Data buffer enable, 0 during initialization |
| init_done | output | 1 | Sequence complete, sticky until reset |
| ref_interval_q | output | REF_W | Captured refresh interval |
| ras_q | output | TIM_W | Captured row latency |
| cas_q | output | TIM_W | Captured column latency |

## Verification
All outputs are registered. A result tied to edge t is therefore visible from the falling edge that follows t and stays until edge t+1. The NOP strobe is due at t = PWRUP_CYC, the precharge strobe at PWRUP_CYC + SETTLE_CYC, the k-th forced refresh REF_GAP*k cycles after that, and the load one cycle after the last forced refresh. The bench keeps its own edge count, updated on every rising edge from the reset level it drove, and compares every output at each falling edge against functions of that count. Operational refreshes are predicted from the interval value the bench latched at the load edge.

// File: rtl/sdram_pu_pkg.sv
package sdram_pu_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP  = 3'd0,
    ST_SETTLE = 3'd1,
    ST_REFR   = 3'd2,
    ST_LOAD   = 3'd3,
    ST_RUN    = 3'd4
  } pu_state_t;

  localparam logic [1:0] CMD_NOP  = 2'b11;
  localparam logic [1:0] CMD_PALL = 2'b10;
  localparam logic [1:0] CMD_NORM = 2'b00;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_pu_timer.sv
module sdram_pu_timer #(
  parameter int W       = 16,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= W'(RST_VAL);
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/sdram_pu_refcnt.sv
module sdram_pu_refcnt #(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic inc,
  output logic last
);

  localparam int CW = $clog2(N + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (inc) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign last = (cnt == CW'(N - 1));

endmodule

// File: rtl/sdram_pu_fsm.sv
module sdram_pu_fsm
  import sdram_pu_pkg::*;
#(
  parameter int TW         = 16,
  parameter int SETTLE_CYC = 20000,
  parameter int REF_GAP    = 16,
  parameter int REF_W      = 12,
  parameter int TIM_W      = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             t_zero,
  input  logic             ref_last,
  input  logic [REF_W-1:0] op_ref_interval,
  input  logic [TIM_W-1:0] op_ras,
  input  logic [TIM_W-1:0] op_cas,
  output logic             t_load,
  output logic [TW-1:0]    t_val,
  output logic             rc_clear,
  output logic             rc_inc,
  output logic [1:0]       init_cmd,
  output logic             cmd_issue,
  output logic             refresh_stb,
  output logic             buf_en,
  output logic             init_done,
  output logic [REF_W-1:0] ref_interval_q,
  output logic [TIM_W-1:0] ras_q,
  output logic [TIM_W-1:0] cas_q
);

  localparam logic [TW-1:0] SETTLE_RLD = TW'(SETTLE_CYC - 1);
  localparam logic [TW-1:0] GAP_RLD    = TW'(REF_GAP - 1);

  pu_state_t st, st_n;

  function automatic logic [TW-1:0] run_reload(input logic [REF_W-1:0] v);
    return (v == '0) ? '0 : (TW'(v) - TW'(1));
  endfunction

  always_comb begin
    st_n     = st;
    t_load   = 1'b0;
    t_val    = '0;
    rc_clear = 1'b0;
    rc_inc   = 1'b0;
    case (st)
      ST_PWRUP: if (t_zero) begin
        t_load = 1'b1;
        t_val  = SETTLE_RLD;
        st_n   = ST_SETTLE;
      end
      ST_SETTLE: if (t_zero) begin
        t_load   = 1'b1;
        t_val    = GAP_RLD;
        rc_clear = 1'b1;
        st_n     = ST_REFR;
      end
      ST_REFR: if (t_zero) begin
        t_load = 1'b1;
        t_val  = GAP_RLD;
        rc_inc = 1'b1;
        if (ref_last) st_n = ST_LOAD;
      end
      ST_LOAD: begin
        t_load = 1'b1;
        t_val  = run_reload(op_ref_interval);
        st_n   = ST_RUN;
      end
      ST_RUN: if (t_zero) begin
        t_load = 1'b1;
        t_val  = run_reload(ref_interval_q);
      end
      default: st_n = ST_PWRUP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st             <= ST_PWRUP;
      init_cmd       <= CMD_NOP;
      cmd_issue      <= 1'b0;
      refresh_stb    <= 1'b0;
      buf_en         <= 1'b0;
      init_done      <= 1'b0;
      ref_interval_q <= '0;
      ras_q          <= '0;
      cas_q          <= '0;
    end else begin
      st          <= st_n;
      cmd_issue   <= ((st == ST_PWRUP) || (st == ST_SETTLE)) && t_zero;
      refresh_stb <= ((st == ST_REFR) || (st == ST_RUN)) && t_zero;
      if ((st == ST_SETTLE) && t_zero) init_cmd <= CMD_PALL;
      if (st == ST_LOAD) begin
        init_cmd       <= CMD_NORM;
        init_done      <= 1'b1;
        buf_en         <= 1'b1;
        ref_interval_q <= op_ref_interval;
        ras_q          <= op_ras;
        cas_q          <= op_cas;
      end
    end
  end

endmodule

// File: rtl/sdram_pu_seq.sv
module sdram_pu_seq
  import sdram_pu_pkg::*;
#(
  parameter int PWRUP_CYC  = 10000,
  parameter int SETTLE_CYC = 20000,
  parameter int REF_GAP    = 16,
  parameter int REF_NUM    = 8,
  parameter int REF_W      = 12,
  parameter int TIM_W      = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REF_W-1:0] op_ref_interval,
  input  logic [TIM_W-1:0] op_ras,
  input  logic [TIM_W-1:0] op_cas,
  output logic [1:0]       init_cmd,
  output logic             cmd_issue,
  output logic             refresh_stb,
  output logic             buf_en,
  output logic             init_done,
  output logic [REF_W-1:0] ref_interval_q,
  output logic [TIM_W-1:0] ras_q,
  output logic [TIM_W-1:0] cas_q
);

  localparam int unsigned MAX_DLY =
    max_u(max_u(PWRUP_CYC, SETTLE_CYC), max_u(REF_GAP, 2 ** REF_W));
  localparam int TW = $clog2(MAX_DLY + 1);

  logic          t_load, t_zero, rc_clear, rc_inc, ref_last;
  logic [TW-1:0] t_val;

  sdram_pu_timer #(
    .W       (TW),
    .RST_VAL (PWRUP_CYC - 1)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .zero     (t_zero)
  );

  sdram_pu_refcnt #(
    .N (REF_NUM)
  ) u_refcnt (
    .clk   (clk),
    .rst   (rst),
    .clear (rc_clear),
    .inc   (rc_inc),
    .last  (ref_last)
  );

  sdram_pu_fsm #(
    .TW         (TW),
    .SETTLE_CYC (SETTLE_CYC),
    .REF_GAP    (REF_GAP),
    .REF_W      (REF_W),
    .TIM_W      (TIM_W)
  ) u_fsm (
    .clk             (clk),
    .rst             (rst),
    .t_zero          (t_zero),
    .ref_last        (ref_last),
    .op_ref_interval (op_ref_interval),
    .op_ras          (op_ras),
    .op_cas          (op_cas),
    .t_load          (t_load),
    .t_val           (t_val),
    .rc_clear        (rc_clear),
    .rc_inc          (rc_inc),
    .init_cmd        (init_cmd),
    .cmd_issue       (cmd_issue),
    .refresh_stb     (refresh_stb),
    .buf_en          (buf_en),
    .init_done       (init_done),
    .ref_interval_q  (ref_interval_q),
    .ras_q           (ras_q),
    .cas_q           (cas_q)
  );

endmodule

// File: rtl/sdram_pu_seq_chk.sv
module sdram_pu_seq_chk #(
  parameter int REF_W = 12,
  parameter int TIM_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       init_cmd,
  input logic             cmd_issue,
  input logic             refresh_stb,
  input logic             buf_en,
  input logic             init_done,
  input logic [REF_W-1:0] ref_interval_q,
  input logic [TIM_W-1:0] ras_q,
  input logic [TIM_W-1:0] cas_q
);

  assert_issue_single_R2: assert property (@(posedge clk) disable iff (rst)
    cmd_issue |=> !cmd_issue);

  assert_issue_not_normal_R2: assert property (@(posedge clk) disable iff (rst)
    cmd_issue |-> (init_cmd != 2'b00) && !init_done);

  assert_pall_after_nop_R3: assert property (@(posedge clk) disable iff (rst)
    (init_cmd == 2'b10) |=> (init_cmd == 2'b10) || (init_cmd == 2'b00));

  assert_no_refresh_on_nop_R4: assert property (@(posedge clk) disable iff (rst)
    refresh_stb |-> (init_cmd != 2'b11));

  assert_bufen_off_R6: assert property (@(posedge clk) disable iff (rst)
    !init_done |-> !buf_en);

  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  assert_regs_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    init_done |=> $stable(ref_interval_q) && $stable(ras_q) && $stable(cas_q));

  assert_code_legal_R9: assert property (@(posedge clk) disable iff (rst)
    init_cmd != 2'b01);

  assert_normal_held_R9: assert property (@(posedge clk) disable iff (rst)
    (init_cmd == 2'b00) |=> (init_cmd == 2'b00));

  assert_normal_means_done_R5: assert property (@(posedge clk) disable iff (rst)
    (init_cmd == 2'b00) |-> init_done);

endmodule

bind sdram_pu_seq sdram_pu_seq_chk #(
  .REF_W (REF_W),
  .TIM_W (TIM_W)
) u_chk (.*);

// File: tb/sdram_pu_seq_bench.sv
module sdram_pu_seq_bench;

  localparam int P  = 23;
  localparam int S  = 37;
  localparam int G  = 16;
  localparam int N  = 8;
  localparam int RW = 6;
  localparam int TW = 4;
  localparam int D  = P + S + N * G + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [RW-1:0] op_ref_interval = '0;
  logic [TW-1:0] op_ras = '0;
  logic [TW-1:0] op_cas = '0;
  logic [1:0]    init_cmd;
  logic          cmd_issue, refresh_stb, buf_en, init_done;
  logic [RW-1:0] ref_interval_q;
  logic [TW-1:0] ras_q, cas_q;

  int tests = 0;
  int fails = 0;
  int t = 0;
  int cycles = 0;
  bit after_cut = 1'b0;
  logic [RW-1:0] cap_ref = '0;
  logic [TW-1:0] cap_ras = '0;
  logic [TW-1:0] cap_cas = '0;

  always #2 clk = ~clk;

  sdram_pu_seq #(
    .PWRUP_CYC  (P),
    .SETTLE_CYC (S),
    .REF_GAP    (G),
    .REF_NUM    (N),
    .REF_W      (RW),
    .TIM_W      (TW)
  ) u_sdram_pu_seq (
    .clk             (clk),
    .rst             (rst),
    .op_ref_interval (op_ref_interval),
    .op_ras          (op_ras),
    .op_cas          (op_cas),
    .init_cmd        (init_cmd),
    .cmd_issue       (cmd_issue),
    .refresh_stb     (refresh_stb),
    .buf_en          (buf_en),
    .init_done       (init_done),
    .ref_interval_q  (ref_interval_q),
    .ras_q           (ras_q),
    .cas_q           (cas_q)
  );

  // Edge count since reset release, and the op values seen at edge D.
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst) begin
      t <= 0;
    end else begin
      t <= t + 1;
      if (t + 1 == D) begin
        cap_ref <= op_ref_interval;
        cap_ras <= op_ras;
        cap_cas <= op_cas;
      end
    end
  end

  function automatic logic [1:0] exp_cmd(input int tt);
    if (tt < P + S) return 2'b11;
    if (tt < D)     return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic exp_issue(input int tt);
    return (tt == P) || (tt == P + S);
  endfunction

  function automatic logic exp_ref(input int tt, input logic [RW-1:0] iv);
    int eff;
    eff = (iv == 0) ? 1 : int'(iv);
    if (tt > P + S && tt <= P + S + N * G) return ((tt - P - S) % G) == 0;
    if (tt > D) return ((tt - D) % eff) == 0;
    return 1'b0;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0d)", req, what, act, exp, t);
    end
  endtask

  task automatic check_all();
    bit done_e;
    string rq;
    done_e = (t >= D);
    if (t == 0) begin
      chk("R1", "init_cmd", init_cmd, 3);
      chk("R1", "cmd_issue", cmd_issue, 0);
      chk("R1", "refresh_stb", refresh_stb, 0);
      chk("R1", "buf_en", buf_en, 0);
      chk("R1", "init_done", init_done, 0);
      chk("R1", "ref_interval_q", ref_interval_q, 0);
      chk("R1", "ras_q", ras_q, 0);
      chk("R1", "cas_q", cas_q, 0);
      return;
    end
    rq = (t < P + S) ? "R2" : (t < D) ? "R3" : "R5";
    if (after_cut && t <= P + S) rq = "R10";
    chk(rq, "cmd_issue", cmd_issue, exp_issue(t));
    chk((t < D) ? rq : "R9", "init_cmd", init_cmd, exp_cmd(t));
    chk((t <= D) ? "R4" : "R8", "refresh_stb", refresh_stb, exp_ref(t, cap_ref));
    chk("R6", "buf_en", buf_en, done_e);
    chk((t > D) ? "R7" : "R5", "init_done", init_done, done_e);
    chk((t > D) ? "R7" : "R5", "ref_interval_q", ref_interval_q, done_e ? cap_ref : 0);
    chk((t > D) ? "R7" : "R5", "ras_q", ras_q, done_e ? cap_ras : 0);
    chk((t > D) ? "R7" : "R5", "cas_q", cas_q, done_e ? cap_cas : 0);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin : watchdog
    wait (cycles > 100000);
    tests++;
    fails++;
    $display("FAIL R1 watchdog: actual %0d cycles expected fewer than %0d", cycles, 100000);
    finish_run();
  end

  initial begin : main
    void'($urandom(32'd24681));
    rst = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check_all();
    end
    for (int e = 0; e < 14; e++) begin
      int len;
      bit cut;
      case (e)
        0: op_ref_interval = '0;
        1: op_ref_interval = RW'(1);
        2: op_ref_interval = '1;
        default: op_ref_interval = RW'(2 + $urandom % 20);
      endcase
      op_ras = TW'($urandom);
      op_cas = TW'($urandom);
      cut = (e % 4 == 3);
      rst = 1'b1;
      repeat (1 + $urandom % 3) begin
        @(negedge clk);
        check_all();
      end
      rst = 1'b0;
      len = cut ? (5 + int'($urandom % (D - 10))) : (D + 60 + int'($urandom % 70));
      for (int k = 0; k < len; k++) begin
        @(negedge clk);
        check_all();
        if (t >= D) begin
          op_ref_interval = RW'($urandom);
          op_ras = TW'($urandom);
          op_cas = TW'($urandom);
        end
      end
      after_cut = cut;
    end
    finish_run();
  end

endmodule